// File: doc/BRIEF.md
# System Management Interrupt Pin Interface

This block owns the two system-management pins of a processor bus interface: the interrupt request line (SMI#, active low) and a companion output pin. A small configuration register inside it holds three bits: a pin-enable bit, a protocol-select bit and a lock bit. The protocol-select bit picks one of two pin protocols. In native protocol the request line is level sampled on every clock, and the core may drive it low itself. In that protocol the companion pin pulses low for each bus cycle that addresses system-management memory. In legacy protocol the request line is an input only and reacts to falling edges. In that protocol the companion pin stays low for the whole service routine.

The core sees the result in three ways. A request flag stays high until the core acknowledges it. An I/O-trap flag rises when a ready strobe ends an I/O cycle that the request led by enough clocks. The bench or chip models each tri-state pin as a drive value plus an output enable. After reset both pins are released and incoming requests are ignored until software sets the enable bit. Once the lock bit is written, only a hardware reset can change the protocol again.

Top module: `smi_pin_if`

## Requirements
- R1: After reset, the register reads all zero (enable at bit 0, protocol at bit 3, lock at bit 4). The request and trap flags are low and both pin output enables are low.
- R2: While the enable bit is 0, a low level on the request line sets neither the request nor the trap flag, and both pins stay undriven.
- R3: A register write loads the protocol bit and the lock bit only while the stored lock bit is 0. Once the lock is 1 those two bits keep their value until reset. The enable bit stays writable at all times.
- R4: In native protocol (bit 3 = 0), a low sample of the request line at a rising edge raises the request flag after that edge. The flag holds until an edge with acknowledge high and no new low sample.
- R5: In legacy protocol (bit 3 = 1), only a high-to-low change of the sampled line raises the request flag. A one-clock pulse stays pending until it is acknowledged. A line held low after the acknowledge does not raise the flag again.
- R6: In native protocol, the trap flag is high for the cycle after an edge where RDY# is low during an I/O cycle, provided the line was sampled low 2 to 4 edges earlier. BRDY# does not qualify.
- R7: In legacy protocol, the trap flag is high for the cycle after an edge where RDY# or BRDY# is low during an I/O cycle, provided a falling edge was seen 3 to 4 edges earlier.
- R8: A ready strobe outside an I/O cycle never raises the trap flag, and a lead shorter than the protocol's minimum or older than 4 edges does not either.
- R9: In native protocol, the request line is driven low in the cycle after each edge that sees the service-active input high. The block's own drive never raises the request flag.
- R10: In legacy protocol the request line is never driven.
- R11: In native protocol, the companion pin is driven whenever enabled. It is low for the cycle after an edge where the address strobe and the SMM-hit input are both high, and high otherwise, whatever the service-active input does.
- R12: In legacy protocol, the companion pin is low in the cycle after each edge that sees service-active high, even when the SMM-hit input is low.
- R13: The software-entry input raises the request flag in native protocol and is ignored in legacy protocol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Hardware reset, active low |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrData | input | 8 | Register write data |
| cfgRdData | output | 8 | Register contents |
| smiPinIn | input | 1 | Level seen on the request line |
| smiPinOut | output | 1 | Drive value for the request line (low) |
| smiPinOe | output | 1 | Output enable of the request line |
| auxPinOut | output | 1 | Drive value of the companion pin, active low |
| auxPinOe | output | 1 | Output enable of the companion pin |
| busIo | input | 1 | Current bus cycle is an I/O cycle |
| rdyN | input | 1 | Non-burst ready, active low |
| brdyN | input | 1 | Burst ready, active low |
| addrStrobe | input | 1 | Start of a bus cycle |
| smmHit | input | 1 | Current access falls in SMM memory |
| svcActive | input | 1 | Service routine is running |
| swSmi | input | 1 | Software entry request from the core |
| coreAck | input | 1 | Core accepts the pending request |
| smiReq | output | 1 | Pending request to the core |
| ioTrap | output | 1 | I/O trap indication |

## Verification
The properties assume that the request line reaches the block already synchronous to the clock, with setup met. They also assume that the ready and I/O-cycle inputs are valid at every edge, not only at the end of a bus cycle. The stimulus changes every input two time units after a rising edge. It models the request line as a wired net: the block's own low drive wins over the external level. The stimulus resets the block before every change of protocol, because the lock may already be set. Between trap vectors it leaves enough idle edges for the four-deep history to empty.

// File: rtl/smi_pin_pkg.sv
package smi_pin_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic pinEn;       // pins enabled by software
    logic legacyMode;  // 1 = edge protocol, 0 = native level protocol
    logic readyIo;     // a qualifying ready ends an I/O cycle at this edge
    logic drvSmi;      // request line should be pulled low
    logic auxAssert;   // companion pin should be low
  } smiStrb_t;
endpackage

// File: rtl/smi_pin_ctl.sv
module smi_pin_ctl
  import smi_pin_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int EN_BIT   = 0,
  parameter int MODE_BIT = 3,
  parameter int LOCK_BIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic             busIo,
  input  logic             rdyN,
  input  logic             brdyN,
  input  logic             addrStrobe,
  input  logic             smmHit,
  input  logic             svcActive,
  input  logic             swSmi,
  input  logic             coreAck,
  input  logic             smiEvent,
  output smiStrb_t         strb,
  output logic             smiReq
);
  logic enQ, modeQ, lockQ;
  logic setReq;
  logic unusedCfgBits;

  assign unusedCfgBits = ^cfgWrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      modeQ <= 1'b0;
      lockQ <= 1'b0;
    end else if (cfgWrEn) begin
      enQ <= cfgWrData[EN_BIT];
      if (!lockQ) begin
        modeQ <= cfgWrData[MODE_BIT];
        lockQ <= cfgWrData[LOCK_BIT];
      end
    end
  end

  always_comb begin
    cfgRdData           = '0;
    cfgRdData[EN_BIT]   = enQ;
    cfgRdData[MODE_BIT] = modeQ;
    cfgRdData[LOCK_BIT] = lockQ;
  end

  always_comb begin
    strb.pinEn      = enQ;
    strb.legacyMode = modeQ;
    strb.readyIo    = enQ & busIo & (~rdyN | (modeQ & ~brdyN));
    strb.drvSmi     = enQ & ~modeQ & svcActive;
    strb.auxAssert  = modeQ ? svcActive : (addrStrobe & smmHit);
  end

  assign setReq = smiEvent | (swSmi & ~modeQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) smiReq <= 1'b0;
    else       smiReq <= setReq | (smiReq & ~coreAck);
  end

  assert_lock_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> (lockQ && $stable(modeQ)));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (smiReq && !coreAck) |=> smiReq);
endmodule

// File: rtl/smi_pin_dp.sv
module smi_pin_dp
  import smi_pin_pkg::*;
#(
  parameter int HIST_DEPTH  = 4,
  parameter int NATIVE_LEAD = 2,
  parameter int LEGACY_LEAD = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  smiStrb_t strb,
  input  logic     smiPinIn,
  output logic     smiEvent,
  output logic     ioTrap,
  output logic     smiPinOe,
  output logic     auxPinOe,
  output logic     auxPinOut
);
  localparam int NATIVE_SHIFT = NATIVE_LEAD - 1;
  localparam int LEGACY_SHIFT = LEGACY_LEAD - 1;

  logic                  curLow, prevLowQ, fell;
  logic [HIST_DEPTH-1:0] levelHist, edgeHist;
  logic                  nativeHit, legacyHit;

  // own drive masks the sample so the block never requests itself
  assign curLow   = strb.pinEn & ~smiPinIn & ~smiPinOe;
  assign fell     = curLow & ~prevLowQ;
  assign smiEvent = strb.legacyMode ? fell : curLow;

  assign nativeHit = |(levelHist >> NATIVE_SHIFT);
  assign legacyHit = |(edgeHist >> LEGACY_SHIFT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLowQ  <= 1'b0;
      levelHist <= '0;
      edgeHist  <= '0;
      ioTrap    <= 1'b0;
    end else begin
      prevLowQ  <= curLow;
      levelHist <= {levelHist[HIST_DEPTH-2:0], curLow};
      edgeHist  <= {edgeHist[HIST_DEPTH-2:0], fell};
      ioTrap    <= strb.readyIo & (strb.legacyMode ? legacyHit : nativeHit);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smiPinOe  <= 1'b0;
      auxPinOe  <= 1'b0;
      auxPinOut <= 1'b1;
    end else begin
      smiPinOe  <= strb.drvSmi;
      auxPinOe  <= strb.pinEn;
      auxPinOut <= ~(strb.pinEn & strb.auxAssert);
    end
  end

  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pinEn |=> (!smiPinOe && !auxPinOe));

  assert_legacy_no_drive_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.legacyMode |=> !smiPinOe);

  assert_trap_needs_io_R8: assert property (@(posedge clk) disable iff (!rstN)
    ioTrap |-> $past(strb.readyIo));
endmodule

// File: rtl/smi_pin_if.sv
module smi_pin_if
  import smi_pin_pkg::*;
#(
  parameter int CFG_W       = 8,
  parameter int HIST_DEPTH  = 4,
  parameter int NATIVE_LEAD = 2,
  parameter int LEGACY_LEAD = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic             smiPinIn,
  output logic             smiPinOut,
  output logic             smiPinOe,
  output logic             auxPinOut,
  output logic             auxPinOe,
  input  logic             busIo,
  input  logic             rdyN,
  input  logic             brdyN,
  input  logic             addrStrobe,
  input  logic             smmHit,
  input  logic             svcActive,
  input  logic             swSmi,
  input  logic             coreAck,
  output logic             smiReq,
  output logic             ioTrap
);
  smiStrb_t strb;
  logic     smiEvent;

  assign smiPinOut = 1'b0;

  smi_pin_ctl #(.CFG_W(CFG_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .busIo(busIo), .rdyN(rdyN), .brdyN(brdyN),
    .addrStrobe(addrStrobe), .smmHit(smmHit), .svcActive(svcActive),
    .swSmi(swSmi), .coreAck(coreAck), .smiEvent(smiEvent), .strb(strb),
    .smiReq(smiReq)
  );

  smi_pin_dp #(.HIST_DEPTH(HIST_DEPTH), .NATIVE_LEAD(NATIVE_LEAD),
               .LEGACY_LEAD(LEGACY_LEAD)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .smiPinIn(smiPinIn),
    .smiEvent(smiEvent), .ioTrap(ioTrap), .smiPinOe(smiPinOe),
    .auxPinOe(auxPinOe), .auxPinOut(auxPinOut)
  );
endmodule

// File: tb/smi_pin_if_tb.sv
module smi_pin_if_tb;
  logic clk = 1'b0;
  logic rstN, cfgWrEn, extSmi, busIo, rdyN, brdyN, addrStrobe, smmHit;
  logic svcActive, swSmi, coreAck;
  logic [7:0] cfgWrData, cfgRdData;
  logic smiPinOut, smiPinOe, auxPinOut, auxPinOe, smiReq, ioTrap;
  logic smiLine;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign smiLine = smiPinOe ? smiPinOut : extSmi;

  smi_pin_if u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .smiPinIn(smiLine), .smiPinOut(smiPinOut),
    .smiPinOe(smiPinOe), .auxPinOut(auxPinOut), .auxPinOe(auxPinOe),
    .busIo(busIo), .rdyN(rdyN), .brdyN(brdyN), .addrStrobe(addrStrobe),
    .smmHit(smmHit), .svcActive(svcActive), .swSmi(swSmi),
    .coreAck(coreAck), .smiReq(smiReq), .ioTrap(ioTrap)
  );

  // {legacy, useBrdy, isIo, gap[2:0], expectTrap}
  localparam logic [6:0] VECS [0:11] = '{
    7'b0010010, 7'b0010101, 7'b0011001, 7'b0011010,
    7'b0110100, 7'b0000100, 7'b1010100, 7'b1010111,
    7'b1110111, 7'b1011001, 7'b1011010, 7'b1100110
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    cfgWrEn = 0; cfgWrData = '0; extSmi = 1; busIo = 0; rdyN = 1; brdyN = 1;
    addrStrobe = 0; smmHit = 0; svcActive = 0; swSmi = 0; coreAck = 0;
  endtask

  task automatic doReset();
    idleInputs();
    rstN = 0;
    tick(); tick();
    rstN = 1;
    tick();
  endtask

  task automatic cfgWrite(input logic [7:0] d);
    cfgWrEn = 1; cfgWrData = d;
    tick();
    cfgWrEn = 0; cfgWrData = '0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    doReset();
    check("R1 cfg", cfgRdData, 8'h00);
    check("R1 outs", {4'b0, smiReq, ioTrap, smiPinOe, auxPinOe}, 8'h00);

    // R2 disabled pins ignore the line
    extSmi = 0;
    tick(); tick();
    busIo = 1; rdyN = 0;
    tick();
    check("R2 req/trap", {6'b0, smiReq, ioTrap}, 8'h00);
    check("R2 oe", {6'b0, smiPinOe, auxPinOe}, 8'h00);
    idleInputs();

    // R3 lock behaviour
    cfgWrite(8'h09);
    check("R3 write unlocked", cfgRdData, 8'h09);
    cfgWrite(8'h11);
    check("R3 set lock", cfgRdData, 8'h11);
    cfgWrite(8'h08);
    check("R3 locked write", cfgRdData, 8'h10);
    doReset();
    check("R3 reset unlocks", cfgRdData, 8'h00);

    // trap vector table: R6 native, R7 legacy, R8 non-I/O and out of window
    for (int i = 0; i < 12; i++) begin
      logic [6:0] v;
      string tag;
      v = VECS[i];
      tag = !v[4] ? "R8 trap no io" : (v[6] ? "R7 trap legacy" : "R6 trap native");
      doReset();
      cfgWrite(v[6] ? 8'h09 : 8'h01);
      tick();
      extSmi = 0;
      tick();
      extSmi = 1;
      repeat (int'(v[3:1]) - 1) tick();
      busIo = v[4]; rdyN = v[5]; brdyN = ~v[5];
      tick();
      check(tag, {7'b0, ioTrap}, {7'b0, v[0]});
      busIo = 0; rdyN = 1; brdyN = 1;
      coreAck = 1; tick(); coreAck = 0;
    end

    // R4 native level request
    doReset();
    cfgWrite(8'h01);
    extSmi = 0;
    tick();
    check("R4 set", {7'b0, smiReq}, 8'h01);
    coreAck = 1;
    tick();
    check("R4 level re-sets", {7'b0, smiReq}, 8'h01);
    extSmi = 1;
    tick();
    check("R4 ack clears", {7'b0, smiReq}, 8'h00);
    coreAck = 0;

    // R5 legacy falling edge
    doReset();
    cfgWrite(8'h09);
    extSmi = 0;
    tick();
    check("R5 edge sets", {7'b0, smiReq}, 8'h01);
    extSmi = 1;
    tick(); tick();
    check("R5 pulse held", {7'b0, smiReq}, 8'h01);
    coreAck = 1;
    tick();
    check("R5 ack clears", {7'b0, smiReq}, 8'h00);
    coreAck = 0; extSmi = 0;
    tick();
    coreAck = 1;
    tick();
    coreAck = 0;
    tick();
    check("R5 held low no retrigger", {7'b0, smiReq}, 8'h00);
    extSmi = 1;

    // R9 native drive, no self request
    doReset();
    cfgWrite(8'h01);
    svcActive = 1;
    tick();
    check("R9 drive", {6'b0, smiPinOe, smiPinOut}, 8'h02);
    tick();
    svcActive = 0;
    tick(); tick();
    check("R9 released no self req", {6'b0, smiPinOe, smiReq}, 8'h00);

    // R10 / R12 legacy pins
    doReset();
    cfgWrite(8'h09);
    svcActive = 1; addrStrobe = 1; smmHit = 0;
    tick();
    check("R12 aux low", {6'b0, auxPinOe, auxPinOut}, 8'h02);
    tick();
    check("R10 no smi drive", {7'b0, smiPinOe}, 8'h00);
    check("R12 aux stays low", {7'b0, auxPinOut}, 8'h00);
    svcActive = 0; addrStrobe = 0;
    tick();
    check("R12 aux release", {7'b0, auxPinOut}, 8'h01);

    // R11 native companion strobe
    doReset();
    cfgWrite(8'h01);
    addrStrobe = 1; smmHit = 1;
    tick();
    check("R11 strobe low", {6'b0, auxPinOe, auxPinOut}, 8'h02);
    addrStrobe = 0;
    tick();
    check("R11 strobe one cycle", {7'b0, auxPinOut}, 8'h01);
    addrStrobe = 1; smmHit = 0; svcActive = 1;
    tick();
    check("R11 no hit, svc ignored", {7'b0, auxPinOut}, 8'h01);
    idleInputs();

    // R13 software entry
    doReset();
    cfgWrite(8'h01);
    swSmi = 1;
    tick();
    check("R13 native sw", {7'b0, smiReq}, 8'h01);
    swSmi = 0;
    doReset();
    cfgWrite(8'h09);
    swSmi = 1;
    tick();
    check("R13 legacy sw ignored", {7'b0, smiReq}, 8'h00);
    swSmi = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule